// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous binary up-counter made from identical 4-bit stages. Every state bit updates on the same rising clock edge. An active-low clear input forces the count to zero at once, with no clock needed. An active-low load input presets the count from a parallel data bus on the next edge.

Two active-high enables control counting. The first enable is common to every stage. The second enable gates counting and also feeds forward into the carry output. Each stage passes its carry to the next stage's second enable, so a chain of stages acts as one wide synchronous counter without any extra gating.

The top module is a wrapper that chains `STAGES` stages. Its data and count buses are `4*STAGES` bits wide. Its carry output is the carry of the last stage, so the wrapper can itself be chained to further counters.

Top module: `casc_counter`

## Requirements
- R1: While `clear_n` is low, `q` is all zeros and `rco` is low. This takes effect at once, with no clock edge, whatever the clock, load and enable inputs are doing.
- R2: When `load_n` is low at a rising edge, and `clear_n` is high, `q` takes the value of `data` at that edge, whatever the levels of `enp` and `ent`.
- R3: When `load_n`, `enp` and `ent` are all high at a rising edge, `q` increases by exactly one over its full width.
- R4: When `load_n` is high and either `enp` or `ent` is low at a rising edge, `q` keeps its value.
- R5: Counting from the all-ones value wraps `q` to all zeros.
- R6: `rco` is high exactly when `q` is all ones and `ent` is high. `rco` follows a change on `ent` within the same cycle, with no register in the path.
- R7: `enp` has no effect on `rco`.
- R8: Changes on `load_n`, `enp` or `ent` between rising edges leave `q` unchanged until the next edge.
- R9: A stage advances only when every lower stage is at 15 and the enables are high. For example, 0x0F counts to 0x10. With `enp` low, a lower stage at 15 does not advance the stage above it.
- R10: Priority is clear first, then load, then count. A load overrides counting even when both enables are high. A clear overrides a load at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all stages |
| clear_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| enp | input | 1 | Count enable shared by all stages |
| ent | input | 1 | Count enable that also gates the carry output |
| data | input | 4*STAGES | Preset value |
| q | output | 4*STAGES | Current count |
| rco | output | 1 | Carry: high at all ones while `ent` is high |

## Verification
Load and count can be requested at the same edge. The bench provokes this by presenting a preset value while both enables are high, and judges the result by whether `q` equals the preset value rather than the incremented count. Clear and load can also meet at one edge. To provoke this, the bench holds the clear low across an edge where a load is pending, and expects `q` to read zero after the edge. The carry is also checked against toggles of `ent` inside one clock period at the all-ones value.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam int STAGE_W = 4;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
  import cnt_pkg::*;
(
  input  logic    load_n,
  input  logic    enp,
  input  logic    ent,
  output cnt_op_e op
);
  // load wins over counting; counting needs both enables
  always_comb begin
    if (!load_n)          op = OP_LOAD;
    else if (enp && ent)  op = OP_COUNT;
    else                  op = OP_HOLD;
  end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int W = STAGE_W
) (
  input  logic         clk,
  input  logic         clear_n,
  input  cnt_op_e      op,
  input  logic         ent,
  input  logic [W-1:0] data,
  output logic [W-1:0] q,
  output logic         rco
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic         q_en;

  // next-state process
  always_comb begin
    q_en  = 1'b1;
    q_nxt = q_r;
    unique case (op)
      OP_LOAD:  q_nxt = data;
      OP_COUNT: q_nxt = q_r + ONE;
      default:  q_en  = 1'b0;
    endcase
  end

  // state register, asynchronous clear
  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n)  q_r <= '0;
    else if (q_en) q_r <= q_nxt;
  end

  assign q   = q_r;
  assign rco = (&q_r) & ent;
endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import cnt_pkg::*;
#(
  parameter int STAGES = 2,
  localparam int WIDTH = STAGES * STAGE_W
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             load_n,
  input  logic             enp,
  input  logic             ent,
  input  logic [WIDTH-1:0] data,
  output logic [WIDTH-1:0] q,
  output logic             rco
);
  logic [STAGES:0] ent_chain;

  assign ent_chain[0] = ent;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    cnt_op_e op_i;

    cnt_mode_dec dec_i (
      .load_n (load_n),
      .enp    (enp),
      .ent    (ent_chain[i]),
      .op     (op_i)
    );

    cnt_stage #(.W(STAGE_W)) stg_i (
      .clk     (clk),
      .clear_n (clear_n),
      .op      (op_i),
      .ent     (ent_chain[i]),
      .data    (data[i*STAGE_W +: STAGE_W]),
      .q       (q[i*STAGE_W +: STAGE_W]),
      .rco     (ent_chain[i+1])
    );
  end

  assign rco = ent_chain[STAGES];
endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             clear_n,
  input logic             load_n,
  input logic             enp,
  input logic             ent,
  input logic [WIDTH-1:0] data,
  input logic [WIDTH-1:0] q,
  input logic             rco
);
  // R1
  always @(posedge clk) begin
    if (!clear_n) clear_zero_chk : assert (q == '0 && !rco);
  end

  // R2
  load_take_chk : assert property (@(posedge clk) disable iff (!clear_n)
    !load_n |=> q == $past(data));

  // R3
  count_step_chk : assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && enp && ent) |=> q == $past(q) + WIDTH'(1));

  // R4
  hold_chk : assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && !(enp && ent)) |=> $stable(q));

  // R6
  carry_chk : assert property (@(posedge clk) disable iff (!clear_n)
    rco == ((&q) && ent));
endmodule

bind casc_counter casc_counter_chk #(.WIDTH(WIDTH)) chk_i (
  .clk     (clk),
  .clear_n (clear_n),
  .load_n  (load_n),
  .enp     (enp),
  .ent     (ent),
  .data    (data),
  .q       (q),
  .rco     (rco)
);

// File: tb/casc_counter_tb_top.sv
module casc_counter_tb_top;
  localparam int STAGES = 2;
  localparam int W      = STAGES * 4;
  localparam logic [W-1:0] ALL1 = '1;

  typedef struct packed {
    logic         load_n;
    logic         enp;
    logic         ent;
    logic [W-1:0] data;
    logic [W-1:0] exp_q;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b1, 8'h0C, 8'h0C},  // R2 preset 12
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h0D},  // R3
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h0E},  // R3
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h0F},  // R3
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h10},  // R9 carry into upper stage
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h11},  // R3
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h12},  // R3
    '{1'b1, 1'b0, 1'b1, 8'h00, 8'h12},  // R4 enp low
    '{1'b0, 1'b1, 1'b1, 8'hFC, 8'hFC},  // R2
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'hFD},  // R3
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'hFE},  // R3
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'hFF},  // R6 carry high
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h00},  // R5 wrap
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h01},  // R3
    '{1'b1, 1'b1, 1'b0, 8'h00, 8'h01},  // R4 ent low
    '{1'b0, 1'b0, 1'b0, 8'hAB, 8'hAB},  // R2 enables low
    '{1'b0, 1'b0, 1'b1, 8'hFF, 8'hFF},  // R7 carry with enp low
    '{1'b1, 1'b0, 1'b0, 8'h00, 8'hFF},  // R6 carry drops with ent
    '{1'b0, 1'b1, 1'b1, 8'h5A, 8'h5A},  // R10 load beats count
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h5B}   // R3
  };

  logic         clk = 1'b0;
  logic         clear_n;
  logic         load_n;
  logic         enp;
  logic         ent;
  logic [W-1:0] data;
  logic [W-1:0] q;
  logic         rco;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  casc_counter #(.STAGES(STAGES)) dut_i (
    .clk     (clk),
    .clear_n (clear_n),
    .load_n  (load_n),
    .enp     (enp),
    .ent     (ent),
    .data    (data),
    .q       (q),
    .rco     (rco)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic ld, input logic p, input logic t, input logic [W-1:0] d);
    @(negedge clk);
    load_n = ld; enp = p; ent = t; data = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    clear_n = 1'b0; load_n = 1'b1; enp = 1'b1; ent = 1'b1; data = '0;
    repeat (2) @(posedge clk);
    #2;
    check("R1 reset q", q, '0);
    check("R1 reset rco", {7'd0, rco}, 8'd0);
    @(negedge clk);
    clear_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].load_n, VECS[i].enp, VECS[i].ent, VECS[i].data);
      @(posedge clk);
      #2;
      check($sformatf("R2/R3/R4/R5/R9/R10 vec %0d q", i), q, VECS[i].exp_q);
      check($sformatf("R6/R7 vec %0d rco", i), {7'd0, rco},
            {7'd0, (VECS[i].exp_q == ALL1) && VECS[i].ent});
    end

    // R6: rco follows ent inside one cycle at all ones
    drive(1'b0, 1'b0, 1'b1, 8'hFF);
    @(posedge clk);
    @(negedge clk);
    load_n = 1'b1; ent = 1'b0;
    #1 check("R6 rco ent low same cycle", {7'd0, rco}, 8'd0);
    ent = 1'b1;
    #1 check("R6 rco ent high same cycle", {7'd0, rco}, 8'd1);
    enp = 1'b1;
    #1 check("R7 rco with enp toggled", {7'd0, rco}, 8'd1);
    enp = 1'b0;

    // R8: mid-cycle control activity does not touch q
    @(negedge clk);
    load_n = 1'b0; data = 8'h33; enp = 1'b1; ent = 1'b1;
    #1 check("R8 q unchanged before edge", q, 8'hFF);
    load_n = 1'b1; enp = 1'b0;
    @(posedge clk);
    #2 check("R8 q held after edge", q, 8'hFF);

    // R9: lower stage at 15 with enp low leaves upper stage alone
    drive(1'b0, 1'b0, 1'b1, 8'h0F);
    @(posedge clk);
    drive(1'b1, 1'b0, 1'b1, 8'h00);
    @(posedge clk);
    #2 check("R9 upper holds with enp low", q, 8'h0F);
    drive(1'b1, 1'b1, 1'b1, 8'h00);
    @(posedge clk);
    #2 check("R9 carry into upper stage", q, 8'h10);

    // R1: asynchronous clear mid-cycle
    @(negedge clk);
    #2 clear_n = 1'b0;
    #1 check("R1 async clear without edge", q, 8'h00);
    // R10: clear held across an edge with load pending
    load_n = 1'b0; data = 8'h77;
    @(posedge clk);
    #2 check("R10 clear beats load", q, 8'h00);
    @(negedge clk);
    clear_n = 1'b1;
    @(posedge clk);
    #2 check("R2 load after clear release", q, 8'h77);

    finish_run();
  end
endmodule